// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block decides when a small processor core may leave reset. Four events can start a reset: a power-on event (the block's own asynchronous reset), an active-low external reset pin, a watchdog timeout and a low-voltage detector trip. A power-on or pin reset powers the oscillator down. The block then waits for a supply-good indication, enables the oscillator and holds the core for a stabilisation count. When an external clock mode is selected, a second count that scales with an 8-bit wake-up prescaler follows the first. A watchdog or low-voltage reset leaves the oscillator running. It holds the core for a single cycle and then releases it.

When the core is released, the block emits a one-cycle start pulse. This pulse tells the core to begin fetching at address zero. A small cause register records which source triggered the most recent reset. Software clears it one bit at a time by writing ones. The pin is only read. No internal event drives it.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While and just after the power-on reset, `osc_en` is 0, `core_rst` is 1, `boot_go` is 0 and `cause` is 4'b0100.
- R2: After a power-on or pin reset, `osc_en` stays 0 and the core stays in reset for as long as `supply_ok` is 0.
- R3: With `clk_mode` = 2'b00 (internal clock), the core is held in reset while `osc_en` is 1 for exactly `STAB_CYCLES` cycles and is then released.
- R4: With any other `clk_mode`, a second count of (`wakeup`+1)×`STAB_CYCLES` cycles follows the first delay. `clk_mode` and `wakeup` are sampled on the last cycle of the first delay. Changing them afterwards has no effect.
- R5: A `wdg_req` or `lvd_req` seen while the core runs keeps `osc_en` at 1, holds `core_rst` at 1 for exactly one cycle and then releases the core.
- R6: `ext_rst_n` is active low and passes through two synchroniser flops. While it is low, the core is in reset and `osc_en` is 0. When it goes high, the sequence of R2 to R4 runs from the start.
- R7: A pin reset during either delay restarts the sequence from the supply wait. A `wdg_req` or `lvd_req` while the core is already in reset changes neither `core_rst` nor `cause`, and does not shorten the delay.
- R8: `boot_go` is a one-cycle pulse in the first cycle that `core_rst` is 0. It tells the core to fetch from address zero.
- R9: `cause` is one-hot for the last trigger: bit0 pin, bit1 watchdog, bit2 power-on, bit3 low voltage. Priority is pin over low voltage over watchdog. A 1 in `cause_clr` clears that bit. A new trigger in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_por_n | input | 1 | Power-on event, asynchronous, active low |
| ext_rst_n | input | 1 | External reset pin, asynchronous, active low, pulled high |
| wdg_req | input | 1 | Watchdog timeout request |
| lvd_req | input | 1 | Low-voltage detector request |
| supply_ok | input | 1 | Supply has crossed its start threshold |
| clk_mode | input | 2 | Clock mode, 2'b00 selects the internal clock |
| wakeup | input | 8 | Wake-up prescaler for the external-clock count |
| cause_clr | input | 4 | Write-one-to-clear strobe for `cause` |
| osc_en | output | 1 | Oscillator enable |
| core_rst | output | 1 | Core reset, active high |
| boot_go | output | 1 | Start pulse: fetch from address zero |
| cause | output | 4 | One-hot reset cause |

## Verification
The assertions assume that `wdg_req` and `lvd_req` are synchronous to `clk`. They also assume that `supply_ok` changes only between edges and does not fall while the core is being released. The bench meets these conditions by driving every input on the falling edge. It raises the supply only after a power-on or pin reset has dropped it. It draws random clock modes, prescaler values and request mixes, and keeps the external pin the only asynchronous stimulus.

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int STAB_CYCLES = 4096,
  parameter int WK_W        = 8
) (
  input  logic            clk,
  input  logic            rst_por_n,
  input  logic            ext_rst_n,
  input  logic            wdg_req,
  input  logic            lvd_req,
  input  logic            supply_ok,
  input  logic [1:0]      clk_mode,
  input  logic [WK_W-1:0] wakeup,
  input  logic [3:0]      cause_clr,
  output logic            osc_en,
  output logic            core_rst,
  output logic            boot_go,
  output logic [3:0]      cause
);

  localparam int CW = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STAB_CYCLES - 1);
  localparam logic [1:0] MODE_INT = 2'b00;

  typedef enum logic [2:0] {S_SUPPLY, S_STAB, S_WAKE, S_QUICK, S_RUN} st_t;

  st_t             st;
  logic [1:0]      pin_sync;
  logic            pin_ok;
  logic [CW-1:0]   cnt;
  logic [WK_W-1:0] blk, wk_q;
  logic            run_d;
  logic            trig_int;
  logic            cnt_end;

  assign pin_ok   = pin_sync[1];
  assign trig_int = (wdg_req || lvd_req) && st == S_RUN && pin_ok;
  assign cnt_end  = cnt == CNT_LAST;
  assign osc_en   = st != S_SUPPLY;
  assign core_rst = st != S_RUN;
  assign boot_go  = st == S_RUN && !run_d;

  always_ff @(posedge clk or negedge rst_por_n)
    if (!rst_por_n) pin_sync <= 2'b11;
    else            pin_sync <= {pin_sync[0], ext_rst_n};

  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n) begin
      st   <= S_SUPPLY;
      cnt  <= '0;
      blk  <= '0;
      wk_q <= '0;
    end else if (!pin_ok) begin
      st  <= S_SUPPLY;
      cnt <= '0;
    end else begin
      case (st)
        S_SUPPLY: if (supply_ok) begin
          st  <= S_STAB;
          cnt <= '0;
        end
        S_STAB: if (cnt_end) begin
          cnt  <= '0;
          blk  <= '0;
          wk_q <= wakeup;
          st   <= (clk_mode == MODE_INT) ? S_RUN : S_WAKE;
        end else cnt <= cnt + 1'b1;
        S_WAKE: if (cnt_end) begin
          cnt <= '0;
          if (blk == wk_q) st <= S_RUN;
          else             blk <= blk + 1'b1;
        end else cnt <= cnt + 1'b1;
        S_QUICK: st <= S_RUN;
        S_RUN:   if (trig_int) st <= S_QUICK;
        default: st <= S_SUPPLY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_por_n)
    if (!rst_por_n) run_d <= 1'b0;
    else            run_d <= st == S_RUN;

  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n)    cause <= 4'b0100;
    else if (!pin_ok)  cause <= 4'b0001;
    else if (trig_int) cause <= lvd_req ? 4'b1000 : 4'b0010;
    else               cause <= cause & ~cause_clr;
  end

endmodule

module rst_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_por_n,
  input logic       pin_ok,
  input logic       wdg_req,
  input logic       lvd_req,
  input logic       supply_ok,
  input logic       osc_en,
  input logic       core_rst,
  input logic       boot_go,
  input logic [3:0] cause
);

  a_r2_supply_gate: assert property (@(posedge clk) disable iff (!rst_por_n)
    $rose(osc_en) |-> $past(supply_ok));

  a_r5_quick_keeps_osc: assert property (@(posedge clk) disable iff (!rst_por_n)
    (!core_rst && (wdg_req || lvd_req) && pin_ok) |=> (osc_en && core_rst));

  a_r3_release_with_osc: assert property (@(posedge clk) disable iff (!rst_por_n)
    $fell(core_rst) |-> osc_en);

  a_r6_pin_holds: assert property (@(posedge clk) disable iff (!rst_por_n)
    !pin_ok |=> (core_rst && !osc_en && cause == 4'b0001));

  a_r8_boot_pulse: assert property (@(posedge clk) disable iff (!rst_por_n)
    boot_go |-> (!core_rst && $past(core_rst)));

  a_r9_cause_onehot: assert property (@(posedge clk) disable iff (!rst_por_n)
    $onehot0(cause));

endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk u_chk (
  .clk(clk), .rst_por_n(rst_por_n), .pin_ok(pin_ok), .wdg_req(wdg_req),
  .lvd_req(lvd_req), .supply_ok(supply_ok), .osc_en(osc_en),
  .core_rst(core_rst), .boot_go(boot_go), .cause(cause)
);

// File: tb/rst_seq_ctrl_tb.sv
module rst_seq_ctrl_tb;
  localparam int STAB = 16;

  logic       clk = 1'b0;
  logic       rst_por_n = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       wdg_req = 1'b0, lvd_req = 1'b0, supply_ok = 1'b0;
  logic [1:0] clk_mode = 2'b00;
  logic [7:0] wakeup = 8'd0;
  logic [3:0] cause_clr = 4'b0;
  logic       osc_en, core_rst, boot_go;
  logic [3:0] cause;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rst_seq_ctrl #(.STAB_CYCLES(STAB), .WK_W(8)) u_dut (
    .clk(clk), .rst_por_n(rst_por_n), .ext_rst_n(ext_rst_n),
    .wdg_req(wdg_req), .lvd_req(lvd_req), .supply_ok(supply_ok),
    .clk_mode(clk_mode), .wakeup(wakeup), .cause_clr(cause_clr),
    .osc_en(osc_en), .core_rst(core_rst), .boot_go(boot_go), .cause(cause)
  );

  function automatic int exp_delay(input logic [1:0] m, input logic [7:0] wk);
    return STAB + ((m == 2'b00) ? 0 : (int'(wk) + 1) * STAB);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pin_reset();
    @(negedge clk);
    ext_rst_n = 1'b0;
    supply_ok = 1'b0;
    repeat (4) @(negedge clk);
    chk(core_rst && !osc_en, "R6 pin low holds", {osc_en, core_rst}, 1);
    chk(cause == 4'b0001, "R9 pin cause", cause, 1);
    ext_rst_n = 1'b1;
  endtask

  task automatic slow_seq(input logic [1:0] m, input logic [7:0] wk, input bit mess,
                          input bit inj, input logic [3:0] exp_cause);
    int n = 0;
    int guard = 0;
    clk_mode = m;
    wakeup = wk;
    repeat (6) @(negedge clk);
    chk(!osc_en && core_rst, "R2 wait supply", {osc_en, core_rst}, 1);
    supply_ok = 1'b1;
    while (guard < 10000) begin
      @(negedge clk);
      guard++;
      wdg_req = 1'b0;
      lvd_req = 1'b0;
      if (!core_rst) break;
      if (osc_en) n++;
      if (mess && n == STAB + 2) begin
        wakeup = ~wk;
        clk_mode = 2'b00;
      end
      if (inj && n == 3) begin
        wdg_req = 1'b1;
        lvd_req = 1'b1;
      end
    end
    chk(n == exp_delay(m, wk), (m == 2'b00) ? "R3 internal delay" : "R4 external delay",
        n, exp_delay(m, wk));
    chk(boot_go == 1'b1, "R8 boot pulse", boot_go, 1);
    if (inj) chk(cause == exp_cause, "R7 ignored req keeps cause", cause, exp_cause);
    @(negedge clk);
    chk(!boot_go && !core_rst, "R8 pulse one cycle", {boot_go, core_rst}, 0);
  endtask

  task automatic quick(input bit w, input bit l, input logic [3:0] clr);
    logic [3:0] ec;
    ec = l ? 4'b1000 : 4'b0010;
    @(negedge clk);
    wdg_req = w;
    lvd_req = l;
    cause_clr = clr;
    @(negedge clk);
    wdg_req = 1'b0;
    lvd_req = 1'b0;
    cause_clr = 4'b0;
    chk(core_rst && osc_en, "R5 quick hold", {osc_en, core_rst}, 3);
    chk(cause == ec, "R9 quick cause", cause, ec);
    @(negedge clk);
    chk(!core_rst && osc_en, "R5 quick release", {osc_en, core_rst}, 2);
    chk(boot_go, "R8 boot after quick", boot_go, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(!osc_en && core_rst && !boot_go && cause == 4'b0100, "R1 reset state",
        {osc_en, core_rst, boot_go, cause}, 32'b0_1_0_0100);
    rst_por_n = 1'b1;
    @(negedge clk);
    chk(!osc_en && core_rst && cause == 4'b0100, "R1 after release",
        {osc_en, core_rst, cause}, 32'b0_1_0100);

    slow_seq(2'b00, 8'd0, 0, 1, 4'b0100);
    quick(1, 0, 4'b0000);
    quick(1, 1, 4'b1111);
    quick(0, 1, 4'b0000);

    @(negedge clk);
    cause_clr = 4'b0100;
    @(negedge clk);
    chk(cause == 4'b1000, "R9 clear other bit", cause, 8);
    cause_clr = 4'b1000;
    @(negedge clk);
    cause_clr = 4'b0;
    chk(cause == 4'b0000, "R9 clear bit", cause, 0);

    pin_reset();
    slow_seq(2'b10, 8'd255, 0, 0, 4'b0001);
    pin_reset();
    slow_seq(2'b01, 8'd3, 1, 1, 4'b0001);

    pin_reset();
    clk_mode = 2'b11;
    wakeup = 8'd2;
    supply_ok = 1'b1;
    repeat (STAB + 5) @(negedge clk);
    chk(osc_en && core_rst, "R7 in second delay", {osc_en, core_rst}, 3);
    pin_reset();
    slow_seq(2'b11, 8'd1, 0, 0, 4'b0001);

    for (int i = 0; i < 14; i++) begin
      logic [1:0] m;
      logic [7:0] wk;
      m  = 2'($urandom_range(0, 3));
      wk = 8'($urandom_range(0, 31));
      pin_reset();
      slow_seq(m, wk, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), 4'b0001);
      quick(bit'($urandom_range(0, 1)), 1'b1, 4'($urandom_range(0, 15)));
      quick(1'b1, 1'b0, 4'b0010);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule